// File: doc/BRIEF.md
# Signed-digit decimal partial product generator

This block forms the partial products of a decimal multiplication. It takes an N-digit packed decimal multiplicand and an M-digit packed decimal multiplier, both in plain 8421 digits. Each multiplier digit is recoded into a signed digit between -5 and +5, and one extra top digit is added for the final transfer. This leaves only five magnitudes to supply. The block builds the multiples 1x to 5x of the multiplicand once, in a redundancy-free 4221 digit code, and shares them among all partial products.

Each partial product selects the multiple that matches its digit's magnitude. When the digit is negative, the product is inverted bit by bit, which gives the nine's complement in this code, and a flag marks the +1 that the downstream reduction tree must add at that product's lowest digit. The multiples are formed without decimal carry correction. Doubling regroups each digit into a 5421 form and shifts the whole vector left one bit. Five times is a three-bit left shift read as 5421. Three times is the only true decimal addition. The logic is combinational, with an optional output register.

Top module: `dec_pp_gen`

## Requirements
- R1: Multiplier digit x_i (i = 0 is least significant) is recoded with a transfer t_i = 1 when x_i >= 5, and a signed digit y_i = x_i + t_(i-1) - 10*t_i, where t_(-1) = 0. Partial product i carries y_i for i < M, and partial product M carries y_M = t_(M-1). Flag `neg_o[i]` is 1 exactly when y_i < 0.
- R2: Every output digit uses the reduced 4221 code: the values 0..9 are 0000, 0001, 0010, 0011, 0110, 1001, 1100, 1101, 1110, 1111, and the value of a digit is 4*b3 + 2*b2 + 2*b1 + b0.
- R3: Each partial product is N+2 digits wide, and digit d of product i sits at `pp_o[(i*(N+2)+d)*4 +: 4]`. Its most significant digit is a sign extension digit: 0000 when `neg_o[i]` is 0 and 1111 when it is 1.
- R4: For y_i > 0, the low N+1 digits of product i hold y_i*A in 4221, so each of the multiples 1A through 5A is reproduced exactly.
- R5: For y_i < 0, the low N+1 digits are the bitwise inverse of |y_i|*A. The signed value is then (digits + neg) - 10^(N+2) = y_i*A.
- R6: When y_i = 0, product i is all zero bits and `neg_o[i]` is 0.
- R7: The top product M is never negative. It equals A when the most significant multiplier digit is 5 or more, and zero otherwise.
- R8: The sum over i of value_i * 10^i equals A*B for all valid operands, where value_i is the signed value defined by R3 to R5.
- R9: With REG_OUT = 1 the outputs change one clock after the operands change. A synchronous reset clears `pp_o` and `neg_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | N_DIG*4 | Multiplicand, 8421 digits, least significant digit in bits 3:0 |
| b_i | input | M_DIG*4 | Multiplier, 8421 digits, least significant digit in bits 3:0 |
| pp_o | output | (M_DIG+1)*(N_DIG+2)*4 | M+1 partial products in reduced 4221, product i at slice i |
| neg_o | output | M_DIG+1 | Per-product sign, which also requests the +1 at that product's lowest digit |

## Verification
Single-digit multipliers 1 to 9 in each position select each magnitude once, both with and without a transfer, so a wrong multiple or a wrong selection line shows up in one product. Digits around the 4/5 boundary and chains of nines separate the transfer logic from the magnitude logic: an all-nines multiplier must give -1 at the bottom, zeros in between and +1 on top. Zero operands and all-nines operands expose sign-extension and complement faults. Random operand pairs then test the weighted sum against an integer product.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    localparam int DIG_W = 4;

    typedef logic [DIG_W-1:0] dig_t;

    // signed multiplier digit: sign plus one-hot choice among 1x..5x
    typedef struct packed {
        logic       neg;
        logic [4:0] sel;
    } sd_t;

    // plain 8421 value to redundancy-free 4221 form
    function automatic dig_t to_r4221(input dig_t d);
        dig_t r;
        case (d)
            4'd0:    r = 4'b0000;
            4'd1:    r = 4'b0001;
            4'd2:    r = 4'b0010;
            4'd3:    r = 4'b0011;
            4'd4:    r = 4'b0110;
            4'd5:    r = 4'b1001;
            4'd6:    r = 4'b1100;
            4'd7:    r = 4'b1101;
            4'd8:    r = 4'b1110;
            4'd9:    r = 4'b1111;
            default: r = 4'b0000;
        endcase
        return r;
    endfunction

    // 8421 digit to 5421 form (top bit weighs five)
    function automatic dig_t to_5421(input dig_t d);
        return (d > 4'd4) ? d + 4'd3 : d;
    endfunction

    // 5421 digit back to 8421
    function automatic dig_t from_5421(input dig_t c);
        return c[3] ? ({1'b0, c[2:0]} + 4'd5) : {1'b0, c[2:0]};
    endfunction

    function automatic logic is_r4221(input dig_t c);
        return !(c inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd10, 4'd11});
    endfunction

endpackage

// File: rtl/dpp_sd_recoder.sv
module dpp_sd_recoder
    import dpp_pkg::*;
#(
    parameter int M_DIG = 4
) (
    input  logic [M_DIG*DIG_W-1:0] b_i,
    output sd_t  [M_DIG:0]         sd_o
);

    always_comb begin
        logic       carry;
        dig_t       x;
        logic [4:0] v;
        logic [4:0] mag;
        logic       ng;
        carry = 1'b0;
        sd_o  = '0;
        for (int i = 0; i < M_DIG; i++) begin
            x = b_i[i*DIG_W +: DIG_W];
            v = {1'b0, x} + {4'b0, carry};
            if (x >= 4'd5) begin
                // digit minus ten: magnitude is ten minus the sum
                carry = 1'b1;
                mag   = 5'd10 - v;
                ng    = (mag != 5'd0);
            end else begin
                carry = 1'b0;
                mag   = v;
                ng    = 1'b0;
            end
            sd_o[i].neg = ng;
            sd_o[i].sel = (mag == 5'd0) ? 5'b0 : (5'b00001 << (mag - 5'd1));
        end
        sd_o[M_DIG].neg = 1'b0;
        sd_o[M_DIG].sel = {4'b0, carry};
    end

endmodule

// File: rtl/dpp_doubler.sv
module dpp_doubler
    import dpp_pkg::*;
#(
    parameter int ND = 5
) (
    input  logic [ND*DIG_W-1:0] bcd_i,
    output logic [ND*DIG_W-1:0] dbl_o
);

    logic [ND*DIG_W-1:0] c5421;

    for (genvar i = 0; i < ND; i++) begin : g_dig
        assign c5421[i*DIG_W +: DIG_W] = to_5421(bcd_i[i*DIG_W +: DIG_W]);
    end

    // the five-weight bit of each digit moves into the next digit's unit bit
    assign dbl_o = c5421 << 1;

endmodule

// File: rtl/dpp_bcd_adder.sv
module dpp_bcd_adder
    import dpp_pkg::*;
#(
    parameter int ND = 5
) (
    input  logic [ND*DIG_W-1:0] a_i,
    input  logic [ND*DIG_W-1:0] b_i,
    output logic [ND*DIG_W-1:0] sum_o
);

    always_comb begin
        logic       cy;
        logic [4:0] s;
        cy    = 1'b0;
        sum_o = '0;
        for (int i = 0; i < ND; i++) begin
            s = {1'b0, a_i[i*DIG_W +: DIG_W]} + {1'b0, b_i[i*DIG_W +: DIG_W]} + {4'b0, cy};
            if (s > 5'd9) begin
                s  = s + 5'd6;
                cy = 1'b1;
            end else begin
                cy = 1'b0;
            end
            sum_o[i*DIG_W +: DIG_W] = s[3:0];
        end
    end

endmodule

// File: rtl/dpp_multiples.sv
module dpp_multiples
    import dpp_pkg::*;
#(
    parameter int N_DIG = 4
) (
    input  logic [N_DIG*DIG_W-1:0]               a_i,
    output logic [4:0][(N_DIG+1)*DIG_W-1:0]      mult_o
);

    localparam int ND = N_DIG + 1;
    localparam int MW = ND * DIG_W;

    logic [MW-1:0] x1, x2, x3, x4, x5, a_sh;
    logic [4:0][MW-1:0] m8421;

    assign x1 = {{DIG_W{1'b0}}, a_i};

    dpp_doubler #(.ND(ND)) u_x2 (.bcd_i(x1), .dbl_o(x2));
    dpp_doubler #(.ND(ND)) u_x4 (.bcd_i(x2), .dbl_o(x4));
    dpp_bcd_adder #(.ND(ND)) u_x3 (.a_i(x1), .b_i(x2), .sum_o(x3));

    // times ten halved: a three-bit shift regroups the bits into 5421 digits
    assign a_sh = x1 << 3;
    for (genvar d = 0; d < ND; d++) begin : g_x5
        assign x5[d*DIG_W +: DIG_W] = from_5421(a_sh[d*DIG_W +: DIG_W]);
    end

    assign m8421 = {x5, x4, x3, x2, x1};

    for (genvar k = 0; k < 5; k++) begin : g_mul
        for (genvar d = 0; d < ND; d++) begin : g_dig
            assign mult_o[k][d*DIG_W +: DIG_W] = to_r4221(m8421[k][d*DIG_W +: DIG_W]);
        end
    end

endmodule

// File: rtl/dpp_pp_select.sv
module dpp_pp_select
    import dpp_pkg::*;
#(
    parameter int N_DIG = 4
) (
    input  sd_t                              sd_i,
    input  logic [4:0][(N_DIG+1)*DIG_W-1:0]  mult_i,
    output logic [(N_DIG+2)*DIG_W-1:0]       pp_o
);

    localparam int MW = (N_DIG + 1) * DIG_W;

    always_comb begin
        logic [MW-1:0] mag;
        mag = '0;
        for (int k = 0; k < 5; k++) begin
            if (sd_i.sel[k]) mag = mag | mult_i[k];
        end
        pp_o = {{DIG_W{sd_i.neg}}, mag ^ {MW{sd_i.neg}}};
    end

endmodule

// File: rtl/dec_pp_gen.sv
module dec_pp_gen
    import dpp_pkg::*;
#(
    parameter int N_DIG   = 4,
    parameter int M_DIG   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_DIG*4-1:0]                     a_i,
    input  logic [M_DIG*4-1:0]                     b_i,
    output logic [(M_DIG+1)*(N_DIG+2)*4-1:0]       pp_o,
    output logic [M_DIG:0]                         neg_o
);

    localparam int MW  = (N_DIG + 1) * DIG_W;
    localparam int PW  = MW + DIG_W;
    localparam int NPP = M_DIG + 1;

    sd_t  [M_DIG:0]     sd;
    logic [4:0][MW-1:0] mult;
    logic [NPP*PW-1:0]  pp_c;
    logic [M_DIG:0]     neg_c;

    dpp_sd_recoder #(.M_DIG(M_DIG)) u_rec (.b_i(b_i), .sd_o(sd));
    dpp_multiples  #(.N_DIG(N_DIG)) u_mul (.a_i(a_i), .mult_o(mult));

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        dpp_pp_select #(.N_DIG(N_DIG)) u_sel (
            .sd_i   (sd[i]),
            .mult_i (mult),
            .pp_o   (pp_c[i*PW +: PW])
        );
        assign neg_c[i] = sd[i].neg;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                pp_o  <= '0;
                neg_o <= '0;
            end else begin
                pp_o  <= pp_c;
                neg_o <= neg_c;
            end
        end
    end else begin : g_comb
        assign pp_o  = pp_c;
        assign neg_o = neg_c;
    end

endmodule

// File: rtl/dec_pp_gen_chk.sv
module dec_pp_gen_chk
    import dpp_pkg::*;
#(
    parameter int N_DIG   = 4,
    parameter int M_DIG   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                              clk,
    input logic                              rst,
    input logic [N_DIG*4-1:0]                a_i,
    input logic [M_DIG*4-1:0]                b_i,
    input logic [(M_DIG+1)*(N_DIG+2)*4-1:0]  pp_o,
    input logic [M_DIG:0]                    neg_o
);

    localparam int MW  = (N_DIG + 1) * 4;
    localparam int PW  = MW + 4;
    localparam int NPP = M_DIG + 1;

    logic [N_DIG*4-1:0] a_s;
    logic [M_DIG*4-1:0] b_s;

    if (REG_OUT) begin : g_d
        always_ff @(posedge clk) begin
            if (rst) begin
                a_s <= '0;
                b_s <= '0;
            end else begin
                a_s <= a_i;
                b_s <= b_i;
            end
        end
    end else begin : g_nd
        assign a_s = a_i;
        assign b_s = b_i;
    end

    function automatic logic all_codes_ok(input logic [NPP*PW-1:0] v);
        for (int d = 0; d < NPP*PW/4; d++) begin
            if (!is_r4221(v[d*4 +: 4])) return 1'b0;
        end
        return 1'b1;
    endfunction

    AST_CODE_SET: assert property (@(posedge clk) disable iff (rst) all_codes_ok(pp_o)) else $error("code set"); // R2
    AST_LOW_SIGN: assert property (@(posedge clk) disable iff (rst) neg_o[0] == (b_s[3:0] >= 4'd5)) else $error("low sign"); // R1
    AST_ZERO_MULT: assert property (@(posedge clk) disable iff (rst) (b_s == '0) |-> (pp_o == '0 && neg_o == '0)) else $error("zero multiplier"); // R6
    AST_TOP_SMALL: assert property (@(posedge clk) disable iff (rst) (b_s[M_DIG*4-1 -: 4] < 4'd5) |-> (pp_o[M_DIG*PW +: PW] == '0)) else $error("top product"); // R7
    AST_TOP_POS: assert property (@(posedge clk) disable iff (rst) !neg_o[M_DIG]) else $error("top sign"); // R7

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst) pp_o[i*PW+MW +: 4] == {4{neg_o[i]}}) else $error("sign digit"); // R3
        AST_ZERO_MCAND: assert property (@(posedge clk) disable iff (rst) (a_s == '0) |-> (pp_o[i*PW +: MW] == {MW{neg_o[i]}})) else $error("inverted zero"); // R5
    end

endmodule

bind dec_pp_gen dec_pp_gen_chk #(.N_DIG(N_DIG), .M_DIG(M_DIG), .REG_OUT(REG_OUT)) i_chk (.*);

// File: tb/test_dec_pp_gen.sv
module test_dec_pp_gen;

    localparam int N_DIG = 4;
    localparam int M_DIG = 4;
    localparam int PW    = (N_DIG + 2) * 4;
    localparam int NPP   = M_DIG + 1;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [N_DIG*4-1:0]    a;
    logic [M_DIG*4-1:0]    b;
    logic [NPP*PW-1:0]     pp;
    logic [M_DIG:0]        neg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dec_pp_gen #(.N_DIG(N_DIG), .M_DIG(M_DIG), .REG_OUT(1'b1)) i_dec_pp_gen (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .pp_o(pp), .neg_o(neg)
    );

    function automatic longint p10(int n);
        longint r = 1;
        for (int k = 0; k < n; k++) r = r * 10;
        return r;
    endfunction

    function automatic logic [N_DIG*4-1:0] enc_a(longint v);
        logic [N_DIG*4-1:0] r;
        for (int k = 0; k < N_DIG; k++) r[k*4 +: 4] = 4'((v / p10(k)) % 10);
        return r;
    endfunction

    function automatic logic [M_DIG*4-1:0] enc_b(longint v);
        logic [M_DIG*4-1:0] r;
        for (int k = 0; k < M_DIG; k++) r[k*4 +: 4] = 4'((v / p10(k)) % 10);
        return r;
    endfunction

    function automatic int rec_digit(longint bv, int idx);
        int carry = 0;
        for (int j = 0; j < M_DIG; j++) begin
            int x;
            int y;
            x = int'((bv / p10(j)) % 10);
            y = x + carry;
            carry = (x >= 5) ? 1 : 0;
            if (carry == 1) y = y - 10;
            if (j == idx) return y;
        end
        return carry;
    endfunction

    function automatic int w4221(logic [3:0] c);
        return 4*c[3] + 2*c[2] + 2*c[1] + c[0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_check(longint av, longint bv);
        longint total = 0;
        @(negedge clk);
        a = enc_a(av);
        b = enc_b(bv);
        @(posedge clk);
        #1;
        for (int i = 0; i < NPP; i++) begin
            int                y;
            logic [PW-1:0]     pv;
            bit                codes;
            longint            dval;
            longint            val;
            y = rec_digit(bv, i);
            pv = pp[i*PW +: PW];
            codes = 1'b1;
            dval = 0;
            for (int d = 0; d < N_DIG + 2; d++) begin
                if (!(pv[d*4 +: 4] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
                    codes = 1'b0;
                dval = dval + longint'(w4221(pv[d*4 +: 4])) * p10(d);
            end
            val = dval + longint'(neg[i]) - (neg[i] ? p10(N_DIG + 2) : 0);
            check(codes, "R2", "digit code", longint'(codes), 1);
            check(neg[i] == (y < 0), "R1", "sign flag", longint'(neg[i]), longint'(y < 0));
            check(pv[PW-1 -: 4] == {4{neg[i]}}, "R3", "sign digit", longint'(pv[PW-1 -: 4]), neg[i] ? 15 : 0);
            if (y > 0)      check(val == longint'(y) * av, "R4", "positive product", val, longint'(y) * av);
            else if (y < 0) check(val == longint'(y) * av, "R5", "negative product", val, longint'(y) * av);
            else            check(pv == '0 && !neg[i], "R6", "zero product", longint'(pv), 0);
            if (i == M_DIG) begin
                longint topexp;
                topexp = (((bv / p10(M_DIG - 1)) % 10) >= 5) ? av : 0;
                check(!neg[i] && val == topexp, "R7", "top product", val, topexp);
            end
            total = total + val * p10(i);
        end
        check(total == av * bv, "R8", "weighted sum", total, av * bv);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a = enc_a(5678);
        b = enc_b(9999);
        repeat (2) @(posedge clk);
        #1;
        check(pp == '0, "R9", "reset products", longint'(pp[31:0]), 0);
        check(neg == '0, "R9", "reset signs", longint'(neg), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_each_magnitude();
        for (int p = 0; p < M_DIG; p++)
            for (int dgt = 1; dgt <= 9; dgt++)
                apply_check(7396, longint'(dgt) * p10(p));
    endtask

    task automatic t_transfer_edges();
        apply_check(1234, 4949);
        apply_check(1234, 5050);
        apply_check(8888, 4545);
        apply_check(9999, 9999);
        apply_check(6021, 5999);
        apply_check(3107, 495);
    endtask

    task automatic t_zeros();
        apply_check(4321, 0);
        apply_check(0, 5678);
        apply_check(0, 0);
        apply_check(9999, 5);
    endtask

    task automatic t_latency();
        logic [NPP*PW-1:0] snap;
        apply_check(2468, 1357);
        snap = pp;
        @(negedge clk);
        a = enc_a(9753);
        b = enc_b(8642);
        #1;
        check(pp == snap, "R9", "output held before edge", longint'(pp[31:0]), longint'(snap[31:0]));
        @(posedge clk);
        #1;
        check(pp != snap, "R9", "output updated after edge", longint'(pp[31:0]), longint'(snap[31:0]));
    endtask

    task automatic t_random();
        for (int n = 0; n < 200; n++)
            apply_check(longint'($urandom_range(0, 9999)), longint'($urandom_range(0, 9999)));
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a = '0;
        b = '0;
        t_reset();
        t_each_magnitude();
        t_transfer_edges();
        t_zeros();
        t_latency();
        t_random();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule